// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Access

This block is a memory-mapped SPI master that moves one byte in each direction per transfer. Software sets the serial clock rate, polarity and phase in a control register. It sets the chip-select level by hand through a system-control register. It starts an exchange by writing the outgoing byte to the transmit register. While the shift engine runs, a busy flag in the status register stays high. When the exchange ends, the incoming byte lands in the receive register and a receive-full flag is set.

The serial clock is derived in two stages. A fixed prescale of 16 or 128 is followed by a programmable even divider. The clock idles at the polarity level, and all four SPI modes are supported. Data leaves and enters most significant bit first.

The register port is a request channel with valid/ready. Ready is held high, so every request is accepted in the cycle it is presented and the requester never sees back-pressure. A read returns its data exactly one cycle after acceptance, flagged by `rd_valid`. The read channel has no ready, so the requester must take the data in that cycle.

Top module: `spi_host_top`

## Requirements
- R1: Every request is accepted in the cycle it is presented (`bus_ready` high), and a read returns data with `rd_valid` high one cycle after acceptance. Address 0x00 is control, 0x04 status, 0x08 system control, 0x0C transmit (reads 0), 0x10 receive and 0x14 reads 0.
- R2: After reset, control, status and receive read 0, system control reads 0x40, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R3: With N = control[4:0] and P = 128 when control[5] is 1 (else 16), each serial clock half period lasts P*(N+1) clock cycles. The first serial clock edge comes exactly one half period after the clock edge that accepts the transmit write.
- R4: Control[6] is the idle level of `spi_sclk` between transfers. With control[7] = 0, `spi_miso` is sampled on leading edges and `spi_mosi` changes on trailing edges. With control[7] = 1, `spi_mosi` changes on leading edges and `spi_miso` is sampled on trailing edges. A transfer has 16 edges, most significant bit first.
- R5: A transmit write starts a transfer only when system control[0] (master enable) is 1 and no transfer is running. Any other transmit write is ignored.
- R6: Status[0] (busy) is 1 from the accepting edge of the transmit write until 17 half periods later.
- R7: When a transfer ends, the received byte is placed at 0x10 and status[2] is set. The flag is cleared by reading 0x10, or by writing status with bit 2 at 0. If a clear and a completion happen in the same cycle, the flag ends set.
- R8: When system control[5] is 1, `spi_cs_n` equals system control[6]. When system control[5] is 0, `spi_cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request ready (always 1) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
Completion of a transfer and a software read of the receive register can land on the same clock edge. One sets the receive-full flag and the other clears it. The bench counts clock cycles from the accepting edge of a transmit write. It uses that count to place a receive read on the exact edge 17 half periods later. It checks that this read returns the previous byte and that the flag then reads set, with busy clear and the new byte waiting. A transmit write during a running transfer is also judged: the slave model must still receive the original byte.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SYS  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TX   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_RX   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_AUX  = 8'h14;

  // bit order matches the control register layout
  typedef struct packed {
    logic       cpha;
    logic       cpol;
    logic       pre_hi;
    logic [4:0] div;
  } ctrl_t;
endpackage

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128,
  parameter int DIV_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             pre_hi,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = $clog2(PRE_HI * (2 ** DIV_W)) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pre_val;
  logic [CNT_W-1:0] limit;

  always_comb begin
    pre_val = pre_hi ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO);
    limit   = pre_val * (CNT_W'(div) + CNT_W'(1));
  end

  assign tick = run && !restart && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || !run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_byte,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rx_byte,
  output logic              sclk,
  output logic              mosi
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic              busy_q;
  logic [EC_W-1:0]   edge_q;
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] rx_q;
  logic              sclk_q;
  logic              leading;
  logic              sample_now;
  logic              shift_now;
  logic              skip_shift;

  always_comb begin
    leading    = ~edge_q[0];
    sample_now = leading ^ cpha;
    skip_shift = cpha ? (edge_q == '0) : (edge_q == EC_W'(EDGES - 1));
    shift_now  = !sample_now && !skip_shift;
  end

  assign done    = busy_q && tick && (edge_q == EC_W'(EDGES));
  assign busy    = busy_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      sclk_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      sh_q   <= tx_byte;
      sclk_q <= cpol;
    end else if (busy_q) begin
      if (done) begin
        busy_q <= 1'b0;
      end else if (tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + EC_W'(1);
        if (sample_now) rx_q <= {rx_q[WORD_W-2:0], miso};
        if (shift_now)  sh_q <= {sh_q[WORD_W-2:0], 1'b0};
      end
    end else begin
      sclk_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              busy,
  input  logic              done,
  input  logic [7:0]        rx_byte,
  output ctrl_t             ctrl,
  output logic              start,
  output logic [7:0]        tx_byte,
  output logic              cs_n
);
  logic       wr_en;
  logic       rd_en;
  ctrl_t      ctrl_q;
  logic       master_en_q;
  logic       swcs_q;
  logic       cs_lvl_q;
  logic       rxfull_q;
  logic [7:0] rxbuf_q;
  logic       rx_clear;
  logic [DATA_W-1:0] rd_mux;
  logic       unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:8];

  assign wr_en   = bus_valid && bus_write;
  assign rd_en   = bus_valid && !bus_write;
  assign start   = wr_en && (bus_addr == OFS_TX) && master_en_q && !busy;
  assign tx_byte = bus_wdata[7:0];
  assign ctrl    = ctrl_q;
  assign cs_n    = swcs_q ? cs_lvl_q : 1'b1;

  assign rx_clear = (rd_en && (bus_addr == OFS_RX)) ||
                    (wr_en && (bus_addr == OFS_STAT) && !bus_wdata[2]);

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL: rd_mux[7:0] = ctrl_q;
      OFS_STAT: rd_mux[2:0] = {rxfull_q, 1'b0, busy};
      OFS_SYS:  rd_mux[6:0] = {cs_lvl_q, swcs_q, 4'b0000, master_en_q};
      OFS_RX:   rd_mux[7:0] = rxbuf_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      master_en_q <= 1'b0;
      swcs_q      <= 1'b0;
      cs_lvl_q    <= 1'b1;
      rxfull_q    <= 1'b0;
      rxbuf_q     <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      if (wr_en && (bus_addr == OFS_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[7:0]);
      if (wr_en && (bus_addr == OFS_SYS)) begin
        master_en_q <= bus_wdata[0];
        swcs_q      <= bus_wdata[5];
        cs_lvl_q    <= bus_wdata[6];
      end
      if (done) begin
        rxfull_q <= 1'b1;
        rxbuf_q  <= rx_byte;
      end else if (rx_clear) begin
        rxfull_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_host_top.sv
module spi_host_top
  import spi_host_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);
  ctrl_t      ctrl_w;
  logic       start_w;
  logic [7:0] tx_w;
  logic [7:0] rx_w;
  logic       busy_w;
  logic       done_w;
  logic       tick_w;

  assign bus_ready = 1'b1;

  spi_host_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy_w), .done(done_w), .rx_byte(rx_w),
    .ctrl(ctrl_w), .start(start_w), .tx_byte(tx_w), .cs_n(spi_cs_n)
  );

  spi_host_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(5)) u_clk (
    .clk(clk), .rst_n(rst_n),
    .run(busy_w), .restart(start_w),
    .pre_hi(ctrl_w.pre_hi), .div(ctrl_w.div), .tick(tick_w)
  );

  spi_host_shifter #(.WORD_W(8)) u_sh (
    .clk(clk), .rst_n(rst_n),
    .start(start_w), .tx_byte(tx_w),
    .cpol(ctrl_w.cpol), .cpha(ctrl_w.cpha),
    .tick(tick_w), .miso(spi_miso),
    .busy(busy_w), .done(done_w), .rx_byte(rx_w),
    .sclk(spi_sclk), .mosi(spi_mosi)
  );
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk
  import spi_host_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              spi_sclk,
  input logic              spi_cs_n,
  input logic              busy,
  input logic              done,
  input logic              cpol,
  input logic              master_en,
  input logic              rxfull
);
  AST_RD_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid);  // R1

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $stable(cpol)) |-> (spi_sclk == cpol));  // R4

  AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_TX && !master_en && !busy) |=> !busy);  // R5

  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);  // R6

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> rxfull);  // R7

  AST_CS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == OFS_SYS && bus_wdata[5] && !bus_wdata[6])
      |=> !spi_cs_n);  // R8
endmodule

bind spi_host_top spi_host_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rd_valid(rd_valid), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
  .busy(busy_w), .done(done_w), .cpol(ctrl_w.cpol),
  .master_en(u_regs.master_en_q), .rxfull(u_regs.rxfull_q)
);

// File: tb/sim_spi_host_top.sv
module sim_spi_host_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready, rd_valid, spi_sclk, spi_mosi, spi_cs_n;
  logic [31:0] rd_data;
  logic        miso_d = 1'b0;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  int unsigned tog = 0;
  bit          ended = 1'b0;

  // slave model state
  logic [7:0] s_tx = '0, s_rx = '0;
  logic       s_cpol = 1'b0, s_cpha = 1'b0;
  int         s_edges = 0;

  always #2 clk = ~clk;

  spi_host_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(miso_d), .spi_cs_n(spi_cs_n)
  );

  always @(spi_sclk) begin
    if ($time > 0) tog++;
    if (spi_cs_n === 1'b0) begin
      if ((spi_sclk != s_cpol) ^ s_cpha) begin
        s_rx = {s_rx[6:0], spi_mosi};
      end else if (!(s_cpha && s_edges == 0)) begin
        s_tx   = {s_tx[6:0], 1'b0};
        miso_d = s_tx[7];
      end
      s_edges++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rd_data;
    chk(rd_valid === 1'b1, "R1 rd_valid", 32'(rd_valid), 32'd1);
  endtask

  task automatic slave_load(input logic [7:0] b, input logic [7:0] c);
    s_tx = b; s_rx = '0; s_edges = 0;
    s_cpol = c[6]; s_cpha = c[7]; miso_d = b[7];
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      bus_rd(8'h04, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  function automatic int half_of(input logic [7:0] c);
    return (c[5] ? 128 : 16) * (int'(c[4:0]) + 1);
  endfunction

  // {ctrl, master byte, slave byte}
  localparam logic [23:0] VEC [6] = '{
    24'h00_A5_3C, 24'h40_81_7E, 24'h80_5A_C3,
    24'hC0_FF_01, 24'h02_96_69, 24'h20_3E_E1
  };

  initial begin
    #600000;
    if (!ended) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  c, mb, sb;
    int          h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state, R1 map
    chk(spi_cs_n === 1'b1, "R2 cs_n", 32'(spi_cs_n), 32'd1);
    chk(spi_sclk === 1'b0, "R2 sclk", 32'(spi_sclk), 32'd0);
    chk(bus_ready === 1'b1, "R1 ready", 32'(bus_ready), 32'd1);
    bus_rd(8'h00, d); chk(d == 32'h0, "R2 ctrl", d, 32'h0);
    bus_rd(8'h04, d); chk(d == 32'h0, "R2 status", d, 32'h0);
    bus_rd(8'h08, d); chk(d == 32'h40, "R2 sysctl", d, 32'h40);
    bus_rd(8'h10, d); chk(d == 32'h0, "R2 rx", d, 32'h0);
    bus_wr(8'h14, 32'hFF); bus_rd(8'h14, d); chk(d == 32'h0, "R1 aux", d, 32'h0);
    bus_wr(8'h00, 32'h9F); bus_rd(8'h00, d); chk(d == 32'h9F, "R1 ctrl rw", d, 32'h9F);
    bus_wr(8'h00, 32'h00);

    // vector table over all modes and rates
    for (int v = 0; v < 6; v++) begin
      c = VEC[v][23:16]; mb = VEC[v][15:8]; sb = VEC[v][7:0];
      bus_wr(8'h00, 32'(c));
      repeat (2) @(negedge clk);
      chk(spi_sclk === c[6], "R4 idle level", 32'(spi_sclk), 32'(c[6]));
      slave_load(sb, c);
      bus_wr(8'h08, 32'h21);
      bus_wr(8'h0C, 32'(mb));
      wait_idle();
      bus_rd(8'h04, d); chk(d == 32'h4, "R7 status after", d, 32'h4);
      bus_rd(8'h10, d); chk(d == 32'(sb), "R4 master rx", d, 32'(sb));
      chk(s_rx == mb, "R4 slave rx", 32'(s_rx), 32'(mb));
      chk(s_edges == 16, "R4 edge count", 32'(s_edges), 32'd16);
      chk(spi_sclk === c[6], "R4 sclk returns idle", 32'(spi_sclk), 32'(c[6]));
      bus_wr(8'h08, 32'h61);
    end
    bus_rd(8'h04, d); chk(d == 32'h0, "R7 cleared by rx read", d, 32'h0);

    // R8 chip select control
    bus_wr(8'h08, 32'h21); chk(spi_cs_n === 1'b0, "R8 cs low", 32'(spi_cs_n), 32'd0);
    bus_wr(8'h08, 32'h61); chk(spi_cs_n === 1'b1, "R8 cs high", 32'(spi_cs_n), 32'd1);
    bus_wr(8'h08, 32'h01); chk(spi_cs_n === 1'b1, "R8 no sw control", 32'(spi_cs_n), 32'd1);

    // R5 ignored when master disabled
    bus_wr(8'h08, 32'h60);
    tog = 0;
    bus_wr(8'h0C, 32'h55);
    repeat (40) @(negedge clk);
    bus_rd(8'h04, d); chk(d[0] == 1'b0, "R5 disabled busy", d, 32'h0);
    chk(tog == 0, "R5 disabled sclk", 32'(tog), 32'd0);

    // R3 first edge timing, R6 busy span, R7 same-cycle set vs read clear
    bus_wr(8'h00, 32'h00);
    h = half_of(8'h00);
    slave_load(8'hB4, 8'h00);
    bus_wr(8'h08, 32'h21);
    bus_wr(8'h0C, 32'h2D);
    repeat (h - 1) @(negedge clk);
    chk(spi_sclk === 1'b0, "R3 no early edge", 32'(spi_sclk), 32'd0);
    @(negedge clk);
    chk(spi_sclk === 1'b1, "R3 first edge", 32'(spi_sclk), 32'd1);
    repeat (17 * h - 2 - h) @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 8'h04;
    @(negedge clk);
    chk(rd_data[0] == 1'b1, "R6 busy before end", rd_data, 32'h1);
    bus_addr = 8'h10;
    @(negedge clk);
    bus_valid = 1'b0;
    chk(rd_data == 32'hE1, "R7 same-cycle old byte", rd_data, 32'hE1);
    bus_rd(8'h04, d); chk(d == 32'h4, "R7 set wins over clear", d, 32'h4);
    bus_rd(8'h10, d); chk(d == 32'hB4, "R7 new byte", d, 32'hB4);
    chk(s_rx == 8'h2D, "R4 slave rx timed", 32'(s_rx), 32'h2D);
    bus_wr(8'h08, 32'h61);

    // R5 write while busy ignored, R7 clear by status write
    slave_load(8'h0F, 8'h00);
    bus_wr(8'h08, 32'h21);
    bus_wr(8'h0C, 32'hC6);
    repeat (50) @(negedge clk);
    bus_wr(8'h0C, 32'h39);
    wait_idle();
    chk(s_rx == 8'hC6, "R5 busy write ignored", 32'(s_rx), 32'hC6);
    bus_wr(8'h04, 32'h0);
    bus_rd(8'h04, d); chk(d == 32'h0, "R7 status write clear", d, 32'h0);
    bus_rd(8'h10, d); chk(d == 32'h0F, "R7 byte kept", d, 32'h0F);
    bus_wr(8'h08, 32'h61);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule